// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block brings a clock fan-out buffer from the power-off state to normal operation. It also handles power-down. It watches four digital indications: a supply-good flag, a shared power-good / power-down control pin, a flag that says the reference input clock is valid, and a PLL lock flag. From these it drives a global output enable and a PLL enable. It also holds the configuration that was sampled at power-up: the frequency choice and the bus address derived from two three-level address selects.

The sequence has four states:
- **Off**: no supply.
- **Ramp**: a timed settling delay.
- **Wait**: waiting for the control pin, the input clock and PLL lock.
- **Run**: outputs enabled.

The control pin has two meanings. The first time it is seen high in the Wait state, the block samples the configuration inputs. From then on, a low level on the pin means power-down. Power-down sends the block from Run back to Wait and shuts the outputs off. Only loss of supply clears the sampled configuration, so that the next power-up samples it again.

While the PLL enable is on and the control pin and the clock are good but lock does not arrive within a set time, the block raises a lock-timeout flag. The supply comparator, the three-level analog decoders and the PLL itself are outside this block. Their results arrive as synchronous digital inputs.

Top module: `clkbuf_pwrseq`

## Requirements
- R1: While reset is asserted, the state is Off (seq_state encoding: 0 Off, 1 Ramp, 2 Wait, 3 Run). During reset, out_en, pll_en, cfg_valid and lock_timeout are all 0.
- R2: The block stays in Off while supply_ok is low. It enters Ramp on the clock edge that samples supply_ok high.
- R3: Ramp lasts RAMP_CYC+1 cycles and then moves to Wait. With the defaults (25000 cycles at 125 MHz) the delay falls between 0.1 ms and 0.3 ms.
- R4: The configuration is sampled only in Wait, on the first cycle the control pin is high. The pin level during Ramp, or a low pin in Wait, samples nothing. cfg_valid rises one cycle after that first high cycle in Wait.
- R5: fs_100m holds the sampled frequency select (1 = 100 MHz, 0 = 133.33 MHz). bus_addr holds the address picked by the two three-level selects. Each select is encoded 00 = low, 01 = mid, 10 or 11 = high. The first select is the major index. The addresses, in order, are: LL D8, LM DA, LH DE, ML C2, MM C4, MH C6, HL CA, HM CC, HH CE.
- R6: Once sampled, fs_100m and bus_addr do not change while the supply stays good. This holds whatever the configuration inputs or the control pin do.
- R7: Run is entered only from Wait, and only when the configuration is valid, the pin is high, the input clock is valid and the PLL is locked. out_en is 1 only in Run. A good pin with no valid clock keeps the outputs off.
- R8: A low control pin in Run returns the block to Wait on the next edge, so out_en drops. pll_en is 0 whenever the pin is low.
- R9: Loss of the valid-clock or lock flag in Run returns the block to Wait on the next edge. pll_en stays 1 while the pin is high.
- R10: A low supply_ok in any state moves the block to Off on the next edge and clears cfg_valid. The next power-up samples the configuration again.
- R11: lock_timeout rises after more than LOCK_CYC consecutive cycles in Wait with the configuration valid, the pin high, the clock valid and no lock. It is 0 outside Wait.
- R12: When the supply rises with the pin high, the clock valid and the PLL locked, out_en is 1 in less than 1.8 ms (225000 cycles at 125 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its minimum threshold |
| pwrgd_pdn | input | 1 | Power-good on first assertion, active-low power-down afterwards |
| clk_in_valid | input | 1 | Reference input clock present |
| pll_locked | input | 1 | PLL locked to the input clock |
| fs_sel_in | input | 1 | Frequency select input, 1 = 100 MHz |
| addr_sel_a | input | 2 | Major three-level address select (decoded) |
| addr_sel_b | input | 2 | Minor three-level address select (decoded) |
| out_en | output | 1 | Global output enable |
| pll_en | output | 1 | PLL enable |
| cfg_valid | output | 1 | Configuration has been sampled |
| fs_100m | output | 1 | Sampled frequency select |
| bus_addr | output | 8 | Sampled bus address |
| lock_timeout | output | 1 | PLL lock did not arrive in time |
| seq_state | output | 2 | Current sequencer state |

## Verification
The hardest thing to reach from the ports is a fresh sampling of the configuration. A second capture needs a full supply drop and another complete Ramp delay. Any change to the select inputs while the supply stays good must have no effect. The stimulus therefore runs three separate power-ups, each with a different select pattern and pin timing. Between them it moves the select inputs and toggles the pin, to show that the held values stay put. Within one power-up, a table of pin, clock and lock combinations moves the block between Wait and Run, and the lock-timeout window is measured in cycles.

// File: rtl/clkbuf_pwrseq_pkg.sv
package clkbuf_pwrseq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_RAMP = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;

  // three-level select, already decoded: 00 low, 01 mid, 1x high
  function automatic logic [3:0] tri_level_idx(input logic [1:0] code);
    logic [3:0] idx;
    case (code)
      2'b00:   idx = 4'd0;
      2'b01:   idx = 4'd1;
      default: idx = 4'd2;
    endcase
    return idx;
  endfunction

  function automatic logic [7:0] addr_from_selects(input logic [1:0] sel_a,
                                                   input logic [1:0] sel_b);
    logic [3:0] pos;
    logic [7:0] addr;
    pos = tri_level_idx(sel_a) * 4'd3 + tri_level_idx(sel_b);
    case (pos)
      4'd0:    addr = 8'hD8;
      4'd1:    addr = 8'hDA;
      4'd2:    addr = 8'hDE;
      4'd3:    addr = 8'hC2;
      4'd4:    addr = 8'hC4;
      4'd5:    addr = 8'hC6;
      4'd6:    addr = 8'hCA;
      4'd7:    addr = 8'hCC;
      default: addr = 8'hCE;
    endcase
    return addr;
  endfunction

endpackage

// File: rtl/clkbuf_pwrseq_timer.sv
module clkbuf_pwrseq_timer #(
  parameter int unsigned LIMIT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LIMIT_V);
  assign cnt_en = clr | (run & ~done);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkbuf_pwrseq_cfg.sv
module clkbuf_pwrseq_cfg
  import clkbuf_pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       capture,
  input  logic       fs_sel_in,
  input  logic [1:0] addr_sel_a,
  input  logic [1:0] addr_sel_b,
  output logic       cfg_valid,
  output logic       fs_100m,
  output logic [7:0] bus_addr
);
  logic       take;
  logic       valid_d;
  logic       valid_en;
  logic [7:0] addr_d;

  assign take     = capture & ~cfg_valid & ~clear;
  assign valid_en = clear | take;
  assign valid_d  = ~clear;
  assign addr_d   = addr_from_selects(addr_sel_a, addr_sel_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_valid <= 1'b0;
    else if (valid_en) cfg_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_100m  <= 1'b0;
      bus_addr <= '0;
    end else if (take) begin
      fs_100m  <= fs_sel_in;
      bus_addr <= addr_d;
    end
  end
endmodule

// File: rtl/clkbuf_pwrseq_fsm.sv
module clkbuf_pwrseq_fsm
  import clkbuf_pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pin_high,
  input  logic       clk_ok,
  input  logic       locked,
  input  logic       cfg_valid,
  input  logic       ramp_done,
  input  logic       tmo_done,
  output seq_state_e state_q,
  output logic       lock_timeout
);
  seq_state_e state_d;
  logic       tmo_d;
  logic       run_ok;

  assign run_ok = pin_high & clk_ok & locked;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = SEQ_OFF;
    end else begin
      case (state_q)
        SEQ_OFF:  state_d = SEQ_RAMP;
        SEQ_RAMP: if (ramp_done) state_d = SEQ_WAIT;
        SEQ_WAIT: if (cfg_valid && run_ok) state_d = SEQ_RUN;
        SEQ_RUN:  if (!run_ok) state_d = SEQ_WAIT;
        default:  state_d = SEQ_OFF;
      endcase
    end
  end

  always_comb begin
    if (state_d != SEQ_WAIT) tmo_d = 1'b0;
    else tmo_d = lock_timeout | ((state_q == SEQ_WAIT) & tmo_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_OFF;
      lock_timeout <= 1'b0;
    end else begin
      state_q      <= state_d;
      lock_timeout <= tmo_d;
    end
  end
endmodule

// File: rtl/clkbuf_pwrseq.sv
module clkbuf_pwrseq
  import clkbuf_pwrseq_pkg::*;
#(
  parameter int unsigned RAMP_CYC = 25000,
  parameter int unsigned LOCK_CYC = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pwrgd_pdn,
  input  logic       clk_in_valid,
  input  logic       pll_locked,
  input  logic       fs_sel_in,
  input  logic [1:0] addr_sel_a,
  input  logic [1:0] addr_sel_b,
  output logic       out_en,
  output logic       pll_en,
  output logic       cfg_valid,
  output logic       fs_100m,
  output logic [7:0] bus_addr,
  output logic       lock_timeout,
  output logic [1:0] seq_state
);
  seq_state_e state_q;
  logic       ramp_done;
  logic       tmo_done;
  logic       in_ramp;
  logic       in_wait;
  logic       lock_wait;
  logic       cfg_take;

  assign in_ramp   = (state_q == SEQ_RAMP);
  assign in_wait   = (state_q == SEQ_WAIT);
  assign lock_wait = in_wait & cfg_valid & pwrgd_pdn & clk_in_valid & ~pll_locked;
  assign cfg_take  = in_wait & pwrgd_pdn;

  clkbuf_pwrseq_timer #(.LIMIT(RAMP_CYC)) u_ramp_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~in_ramp),
    .run   (in_ramp),
    .done  (ramp_done)
  );

  clkbuf_pwrseq_timer #(.LIMIT(LOCK_CYC)) u_lock_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~lock_wait),
    .run   (lock_wait),
    .done  (tmo_done)
  );

  clkbuf_pwrseq_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (~supply_ok),
    .capture    (cfg_take),
    .fs_sel_in  (fs_sel_in),
    .addr_sel_a (addr_sel_a),
    .addr_sel_b (addr_sel_b),
    .cfg_valid  (cfg_valid),
    .fs_100m    (fs_100m),
    .bus_addr   (bus_addr)
  );

  clkbuf_pwrseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .pin_high     (pwrgd_pdn),
    .clk_ok       (clk_in_valid),
    .locked       (pll_locked),
    .cfg_valid    (cfg_valid),
    .ramp_done    (ramp_done),
    .tmo_done     (tmo_done),
    .state_q      (state_q),
    .lock_timeout (lock_timeout)
  );

  assign out_en    = (state_q == SEQ_RUN);
  assign pll_en    = pwrgd_pdn & (in_wait | out_en);
  assign seq_state = state_q;
endmodule

// File: rtl/clkbuf_pwrseq_sva.sv
module clkbuf_pwrseq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       pwrgd_pdn,
  input logic       clk_in_valid,
  input logic       pll_locked,
  input logic       out_en,
  input logic       pll_en,
  input logic       cfg_valid,
  input logic       fs_100m,
  input logic [7:0] bus_addr,
  input logic       lock_timeout,
  input logic [1:0] seq_state
);
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd0 && !supply_ok) |=> seq_state == 2'd0); // R2
  AST_RAMP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1 && supply_ok) |=> (seq_state == 2'd1 || seq_state == 2'd2)); // R3
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && supply_ok) |=> ($stable(bus_addr) && $stable(fs_100m))); // R6
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(pll_locked && clk_in_valid && pwrgd_pdn && supply_ok && cfg_valid)); // R7
  AST_PDN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !pwrgd_pdn) |=> !out_en); // R8
  AST_PLL_OFF_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrgd_pdn |-> !pll_en); // R8
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (seq_state == 2'd0 && !cfg_valid && !out_en)); // R10
  AST_TMO_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_timeout |-> seq_state == 2'd2); // R11
endmodule

bind clkbuf_pwrseq clkbuf_pwrseq_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .pwrgd_pdn    (pwrgd_pdn),
  .clk_in_valid (clk_in_valid),
  .pll_locked   (pll_locked),
  .out_en       (out_en),
  .pll_en       (pll_en),
  .cfg_valid    (cfg_valid),
  .fs_100m      (fs_100m),
  .bus_addr     (bus_addr),
  .lock_timeout (lock_timeout),
  .seq_state    (seq_state)
);

// File: tb/clkbuf_pwrseq_tb.sv
module clkbuf_pwrseq_tb;
  localparam int unsigned RAMP_CYC = 25000;
  localparam int unsigned LOCK_CYC = 12500;
  localparam int unsigned MIN_DLY  = 12500;   // 0.1 ms at 125 MHz
  localparam int unsigned MAX_DLY  = 37500;   // 0.3 ms
  localparam int unsigned MAX_ON   = 225000;  // 1.8 ms
  localparam int unsigned NVEC     = 9;

  // {pin, clk_valid, lock, exp_state[1:0], exp_out_en, exp_pll_en}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b111_11_1_1, 7'b011_10_0_0, 7'b111_11_1_1,
    7'b101_10_0_1, 7'b110_10_0_1, 7'b111_11_1_1,
    7'b110_10_0_1, 7'b000_10_0_0, 7'b111_11_1_1
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok, pwrgd_pdn, clk_in_valid, pll_locked, fs_sel_in;
  logic [1:0] addr_sel_a, addr_sel_b;
  logic       out_en, pll_en, cfg_valid, fs_100m, lock_timeout;
  logic [7:0] bus_addr;
  logic [1:0] seq_state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkbuf_pwrseq #(.RAMP_CYC(RAMP_CYC), .LOCK_CYC(LOCK_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_pdn(pwrgd_pdn),
    .clk_in_valid(clk_in_valid), .pll_locked(pll_locked), .fs_sel_in(fs_sel_in),
    .addr_sel_a(addr_sel_a), .addr_sel_b(addr_sel_b), .out_en(out_en),
    .pll_en(pll_en), .cfg_valid(cfg_valid), .fs_100m(fs_100m),
    .bus_addr(bus_addr), .lock_timeout(lock_timeout), .seq_state(seq_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    summary();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; supply_ok = 1'b0; pwrgd_pdn = 1'b0; clk_in_valid = 1'b0;
    pll_locked = 1'b0; fs_sel_in = 1'b1; addr_sel_a = 2'b01; addr_sel_b = 2'b10;
    step(3);
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 out_en", out_en, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 timeout", lock_timeout, 0);
    rst_n = 1'b1;
    step(50);
    chk("R2 off without supply", seq_state, 0);

    // first power-up: mid/high selects -> C6, 100 MHz
    supply_ok = 1'b1;
    cnt = 0;
    step(1); cnt++;
    chk("R2 ramp entered", seq_state, 1);
    step(20); cnt += 20;
    pwrgd_pdn = 1'b1;
    step(2); cnt += 2;
    chk("R4 no capture in ramp", cfg_valid, 0);
    while (seq_state != 2'd2 && cnt < 60000) begin step(1); cnt++; end
    chk("R3 delay lower bound", 32'(cnt >= MIN_DLY), 1);
    chk("R3 delay upper bound", 32'(cnt <= MAX_DLY), 1);
    step(1);
    chk("R4 captured", cfg_valid, 1);
    chk("R5 addr MH", bus_addr, 8'hC6);
    chk("R5 fs", fs_100m, 1);
    fs_sel_in = 1'b0; addr_sel_a = 2'b10; addr_sel_b = 2'b00;
    pwrgd_pdn = 1'b0; step(3); pwrgd_pdn = 1'b1; step(3);
    chk("R6 addr held", bus_addr, 8'hC6);
    chk("R6 fs held", fs_100m, 1);

    // lock timeout (R11)
    clk_in_valid = 1'b1;
    step(LOCK_CYC / 2);
    chk("R11 no early timeout", lock_timeout, 0);
    chk("R9 pll_en while waiting", pll_en, 1);
    step(LOCK_CYC);
    chk("R11 timeout raised", lock_timeout, 1);
    pll_locked = 1'b1;
    step(1);
    chk("R7 run after lock", seq_state, 3);
    chk("R7 outputs on", out_en, 1);
    chk("R11 timeout cleared", lock_timeout, 0);

    // table walk: R7 R8 R9 transitions between Wait and Run
    for (int i = 0; i < NVEC; i++) begin
      {pwrgd_pdn, clk_in_valid, pll_locked} = VEC[i][6:4];
      addr_sel_b = 2'(i);
      step(2);
      chk($sformatf("R%0d vec %0d state", (i == 1 || i == 7) ? 8 : 9, i), seq_state, VEC[i][3:2]);
      chk($sformatf("R7 vec %0d out_en", i), out_en, VEC[i][1]);
      chk($sformatf("R8 vec %0d pll_en", i), pll_en, VEC[i][0]);
    end
    chk("R6 addr after table", bus_addr, 8'hC6);

    // R10 supply loss, second power-up with all good: HL -> CA, 133 MHz
    supply_ok = 1'b0;
    step(1);
    chk("R10 off", seq_state, 0);
    chk("R10 cfg cleared", cfg_valid, 0);
    chk("R10 outputs off", out_en, 0);
    fs_sel_in = 1'b0; addr_sel_a = 2'b10; addr_sel_b = 2'b00;
    supply_ok = 1'b1;
    cnt = 0;
    while (!out_en && cnt < MAX_ON + 10) begin step(1); cnt++; end
    chk("R12 on time", 32'(cnt < MAX_ON), 1);
    chk("R10 recapture addr HL", bus_addr, 8'hCA);
    chk("R5 fs 133", fs_100m, 0);

    // third power-up: pin low, then no clock; code 11 reads as high -> CE
    supply_ok = 1'b0; pwrgd_pdn = 1'b0; clk_in_valid = 1'b0;
    step(2);
    fs_sel_in = 1'b1; addr_sel_a = 2'b11; addr_sel_b = 2'b11;
    supply_ok = 1'b1;
    cnt = 0;
    while (seq_state != 2'd2 && cnt < 60000) begin step(1); cnt++; end
    step(10);
    chk("R4 no capture with pin low", cfg_valid, 0);
    pwrgd_pdn = 1'b1;
    step(2);
    chk("R4 capture on pin high", cfg_valid, 1);
    chk("R5 addr HH", bus_addr, 8'hCE);
    chk("R7 no clock stays wait", seq_state, 2);
    chk("R7 no clock outputs off", out_en, 0);
    clk_in_valid = 1'b1;
    step(2);
    chk("R7 run with clock", out_en, 1);
    summary();
  end
endmodule